// File: doc/BRIEF.md
# Commonality-Detecting Input Queues for Redundant Voting

This block feeds three redundant processing elements from three independent input streams, one queue per stream. Each stream is taken in on its own valid/ready port and handed out in arrival order to its element through a second valid/ready port. The streams are not in lockstep, so the same operand pattern can turn up at different depths in different queues. Every queue can therefore be searched by content. The pattern at the head of each queue is compared against everything held in the two sibling queues. A pattern that all three queues hold is a voting opportunity.

When an element takes a head pattern that matches in both siblings, the block opens a pending slot for that pattern. It keeps the result that the element returns one cycle later. It then collects the results of the other two elements as they take the same pattern off their own queues. When all three results are present, the block presents the pattern and the three aligned results to a downstream voter, again over valid/ready. The slot holds one pattern at a time. Hits on other patterns are ignored until the voter accepts the pending set. The voting arithmetic itself lies outside the block.

Back-pressure: a stream push is accepted only in a cycle with `in_valid` and `in_ready` both high. `in_ready` is low exactly while that queue is full, so a push offered then is not stored. A head is removed only in a cycle with `pe_valid` and `pe_ready` both high. The vote output, once valid, holds until `vote_ready` is high. Queue depth is any value of 1 or more. Pattern and result widths are parameters, 32 bits by default: a pattern is two 16-bit operands packed together.

Top module: `vote_align_fifos`

## Requirements
- R1: Each stream queue holds up to DEPTH patterns. `in_ready[i]` is low exactly when queue i is full. A push offered while `in_ready[i]` is low is not stored, so it is never handed out later.
- R2: `pe_valid[i]` is high exactly when queue i is non-empty. `pe_data` slice i carries the oldest stored pattern of that queue. Patterns leave in arrival order, one per cycle in which `pe_valid[i]` and `pe_ready[i]` are both high.
- R3: In the same cycle, `hit[i]` is high exactly when queue i is non-empty and its head pattern equals at least one stored pattern in each of the other two queues.
- R4: When no pattern is pending, a pop with `hit[i]` high opens the pending slot with that head pattern. If several streams pop hitting heads with different patterns in one cycle, the lowest stream index wins. Any stream popping the same pattern in that cycle is also collected.
- R5: A result is collected for stream i only from `res_valid[i]`/`res_data` slice i in the cycle right after stream i popped the pending pattern. Only the first such result per stream is kept. Later pops of the same pattern on that stream, and all other results, are ignored.
- R6: While a pattern is pending (including while the vote waits for `vote_ready`), hits on any other pattern are ignored. Such a pattern yields no vote later.
- R7: `vote_valid` rises once results from all three streams are held. `vote_pattern` is the pending pattern. `vote_res` holds the stream 0 result in its low RW bits, stream 1 next, and stream 2 in its top RW bits. All of these stay stable while `vote_ready` is low.
- R8: A cycle with `vote_valid` and `vote_ready` both high empties the slot. `vote_valid` is low in the next cycle and stays low until a new hit has been collected in full.
- R9: While `rst_n` is low, all queues are empty, `in_ready` is all ones, and `pe_valid`, `hit` and `vote_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 3 | Push request per stream |
| in_data | input | 3*W | Pushed pattern, stream i in bits [i*W +: W] |
| in_ready | output | 3 | Queue i can accept (not full) |
| pe_valid | output | 3 | Queue i has a head pattern (not empty) |
| pe_data | output | 3*W | Head pattern of each queue |
| pe_ready | input | 3 | Element i takes its head this cycle |
| res_valid | input | 3 | Element i result valid (one cycle after its pop) |
| res_data | input | 3*RW | Element results, stream i in bits [i*RW +: RW] |
| hit | output | 3 | Head of queue i is held by both sibling queues |
| vote_valid | output | 1 | Aligned result set ready for the voter |
| vote_ready | input | 1 | Voter accepts the set |
| vote_pattern | output | W | Pattern the results belong to |
| vote_res | output | 3*RW | Aligned results, stream 0 lowest |

## Verification
The bench builds the block with 8-bit patterns and results and a queue depth of 4. At that size, filling a queue to the point of refused pushes takes only a few cycles. The same size makes it practical to sweep every combination of 0 to 2 unrelated patterns placed ahead of a common pattern in each of the three queues. In that sweep, the hit mask and the aligned result set are predicted arithmetically from the placements. Directed cases cover the index priority between competing hits, duplicate pops of the pending pattern, and a vote held under back-pressure.

// File: rtl/vaf_pkg.sv
package vaf_pkg;
  localparam int NS = 3;   // redundant streams / processing elements
  localparam int NSIB = NS - 1;  // sibling queues searched per head
endpackage

// File: rtl/vaf_fifo.sv
module vaf_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic [W-1:0]       push_data,
  output logic               push_ready,
  output logic               pop_valid,
  output logic [W-1:0]       pop_data,
  input  logic               pop_ready,
  output logic [DEPTH*W-1:0] entries,
  output logic [DEPTH-1:0]   live
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign push_ready = (cnt_q != CW'(DEPTH));
  assign pop_valid  = (cnt_q != '0);
  assign pop_data   = mem[rd_q];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  // expose storage for content search; live marks occupied slots
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      int off;
      entries[k*W +: W] = mem[k];
      off = (k >= int'(rd_q)) ? (k - int'(rd_q)) : (k + DEPTH - int'(rd_q));
      live[k] = (off < int'(cnt_q));
    end
  end
endmodule

// File: rtl/vaf_cam.sv
module vaf_cam #(
  parameter int W = 32,
  parameter int DEPTH = 32
) (
  input  logic [W-1:0]       key,
  input  logic [DEPTH*W-1:0] entries,
  input  logic [DEPTH-1:0]   live,
  output logic               match
);
  always_comb begin
    match = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (live[k] && (entries[k*W +: W] == key)) match = 1'b1;
    end
  end
endmodule

// File: rtl/vaf_cache.sv
module vaf_cache #(
  parameter int W = 32,
  parameter int RW = 32,
  parameter int NS = vaf_pkg::NS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NS-1:0]  pop,
  input  logic [NS*W-1:0] pop_pat,
  input  logic [NS-1:0]  hit,
  input  logic [NS-1:0]  res_valid,
  input  logic [NS*RW-1:0] res_data,
  output logic           vote_valid,
  input  logic           vote_ready,
  output logic [W-1:0]   vote_pattern,
  output logic [NS*RW-1:0] vote_res
);
  logic           pend_q;
  logic [W-1:0]   pat_q;
  logic [NS-1:0]  got_q, trk_q, trk_d;
  logic [RW-1:0]  res_q [NS];
  logic           start;
  logic [W-1:0]   new_pat;

  // open the slot: lowest hitting stream index wins
  always_comb begin
    start   = 1'b0;
    new_pat = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (!pend_q && pop[i] && hit[i]) begin
        start   = 1'b1;
        new_pat = pop_pat[i*W +: W];
      end
    end
    for (int i = 0; i < NS; i++) begin
      if (pend_q)
        trk_d[i] = pop[i] && (pop_pat[i*W +: W] == pat_q) && !got_q[i] && !trk_q[i];
      else
        trk_d[i] = pop[i] && start && (pop_pat[i*W +: W] == new_pat);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pat_q  <= '0;
      got_q  <= '0;
      trk_q  <= '0;
      for (int i = 0; i < NS; i++) res_q[i] <= '0;
    end else if (vote_valid && vote_ready) begin
      pend_q <= 1'b0;
      got_q  <= '0;
      trk_q  <= '0;
    end else begin
      if (start) begin
        pend_q <= 1'b1;
        pat_q  <= new_pat;
      end
      trk_q <= trk_d;
      for (int i = 0; i < NS; i++) begin
        if (trk_q[i] && res_valid[i]) begin
          got_q[i] <= 1'b1;
          res_q[i] <= res_data[i*RW +: RW];
        end
      end
    end
  end

  assign vote_valid   = pend_q && (&got_q);
  assign vote_pattern = pat_q;
  always_comb begin
    for (int i = 0; i < NS; i++) vote_res[i*RW +: RW] = res_q[i];
  end
endmodule

// File: rtl/vote_align_fifos.sv
module vote_align_fifos #(
  parameter int W = 32,
  parameter int RW = 32,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    in_valid,
  input  logic [3*W-1:0] in_data,
  output logic [2:0]    in_ready,
  output logic [2:0]    pe_valid,
  output logic [3*W-1:0] pe_data,
  input  logic [2:0]    pe_ready,
  input  logic [2:0]    res_valid,
  input  logic [3*RW-1:0] res_data,
  output logic [2:0]    hit,
  output logic          vote_valid,
  input  logic          vote_ready,
  output logic [W-1:0]  vote_pattern,
  output logic [3*RW-1:0] vote_res
);
  import vaf_pkg::*;

  logic [DEPTH*W-1:0] ent_a  [NS];
  logic [DEPTH-1:0]   live_a [NS];
  logic [NSIB-1:0]    sib_m  [NS];

  for (genvar i = 0; i < NS; i++) begin : g_q
    vaf_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_valid(in_valid[i]), .push_data(in_data[i*W +: W]), .push_ready(in_ready[i]),
      .pop_valid(pe_valid[i]), .pop_data(pe_data[i*W +: W]), .pop_ready(pe_ready[i]),
      .entries(ent_a[i]), .live(live_a[i])
    );
  end

  // each head searched in both sibling queues
  for (genvar i = 0; i < NS; i++) begin : g_srch
    for (genvar k = 0; k < NSIB; k++) begin : g_sib
      localparam int J = (i + k + 1) % NS;
      vaf_cam #(.W(W), .DEPTH(DEPTH)) u_cam (
        .key(pe_data[i*W +: W]), .entries(ent_a[J]), .live(live_a[J]),
        .match(sib_m[i][k])
      );
    end
    assign hit[i] = pe_valid[i] && (&sib_m[i]);
  end

  vaf_cache #(.W(W), .RW(RW), .NS(NS)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .pop(pe_valid & pe_ready), .pop_pat(pe_data), .hit(hit),
    .res_valid(res_valid), .res_data(res_data),
    .vote_valid(vote_valid), .vote_ready(vote_ready),
    .vote_pattern(vote_pattern), .vote_res(vote_res)
  );
endmodule

// File: rtl/vote_align_fifos_chk.sv
module vote_align_fifos_chk #(
  parameter int W = 32,
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    in_ready,
  input logic [2:0]    pe_valid,
  input logic [2:0]    hit,
  input logic          vote_valid,
  input logic          vote_ready,
  input logic [W-1:0]  vote_pattern,
  input logic [3*RW-1:0] vote_res
);
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((~in_ready & ~pe_valid) == 3'b000)); // R1

  AST_HIT_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |-> (&pe_valid)); // R3

  AST_VOTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_valid && !vote_ready) |=> (vote_valid && $stable(vote_pattern) && $stable(vote_res))); // R7

  AST_VOTE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_valid && vote_ready) |=> !vote_valid); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!vote_valid && (pe_valid == 3'b000) && (hit == 3'b000))); // R9
endmodule

bind vote_align_fifos vote_align_fifos_chk #(.W(W), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .pe_valid(pe_valid), .hit(hit),
  .vote_valid(vote_valid), .vote_ready(vote_ready),
  .vote_pattern(vote_pattern), .vote_res(vote_res)
);

// File: tb/vote_align_fifos_bench.sv
module vote_align_fifos_bench;
  localparam int W = 8;
  localparam int RW = 8;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] in_valid = 0, pe_ready = 0, res_valid = 0;
  logic [3*W-1:0] in_data = 0;
  logic [3*RW-1:0] res_data = 0;
  logic vote_ready = 0;
  logic [2:0] in_ready, pe_valid, hit;
  logic [3*W-1:0] pe_data;
  logic vote_valid;
  logic [W-1:0] vote_pattern;
  logic [3*RW-1:0] vote_res;

  int total = 0, bad = 0;
  logic [RW-1:0] salt = 0;
  logic [3*W-1:0] last_d;

  always #5 clk = ~clk;

  vote_align_fifos #(.W(W), .RW(RW), .DEPTH(DEPTH)) u_vote_align_fifos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pe_valid(pe_valid), .pe_data(pe_data), .pe_ready(pe_ready),
    .res_valid(res_valid), .res_data(res_data), .hit(hit),
    .vote_valid(vote_valid), .vote_ready(vote_ready),
    .vote_pattern(vote_pattern), .vote_res(vote_res)
  );

  function automatic logic [RW-1:0] fres(input int s, input logic [W-1:0] d);
    return RW'(d) + RW'(17 * (s + 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int s, input logic [W-1:0] v);
    @(negedge clk);
    in_valid[s] = 1'b1;
    in_data[s*W +: W] = v;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // pop masked heads; results driven one cycle after the pop
  task automatic pop(input logic [2:0] m);
    logic [2:0] v;
    @(negedge clk);
    v = pe_valid & m;
    last_d = pe_data;
    pe_ready = v;
    @(posedge clk); #1;
    pe_ready = 0;
    res_valid = v;
    for (int s = 0; s < 3; s++) res_data[s*RW +: RW] = fres(s, last_d[s*W +: W]) ^ salt;
    @(posedge clk); #1;
    res_valid = 0;
  endtask

  task automatic accept();
    @(negedge clk);
    vote_ready = 1'b1;
    @(posedge clk); #1;
    vote_ready = 0;
  endtask

  function automatic logic [3*RW-1:0] exp_res(input logic [W-1:0] p, input logic [3*RW-1:0] x);
    return {fres(2, p), fres(1, p), fres(0, p)} ^ x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 3'b111 && pe_valid == 0 && hit == 0 && !vote_valid, "R9 reset idle",
        {vote_valid, hit, pe_valid, in_ready}, 32'h007);
    rst_n = 1;

    // R1/R2: fill stream 0 past depth, drain in order
    for (int k = 0; k < DEPTH + 1; k++) push(0, 8'h10 + 8'(k));
    @(negedge clk);
    chk(in_ready == 3'b110, "R1 full flag", in_ready, 3'b110);
    chk(pe_valid == 3'b001 && pe_data[7:0] == 8'h10, "R2 head oldest", pe_data[7:0], 8'h10);
    for (int k = 0; k < DEPTH; k++) begin
      pop(3'b001);
      chk(last_d[7:0] == 8'h10 + 8'(k), "R2 order", last_d[7:0], 8'h10 + 8'(k));
    end
    @(negedge clk);
    chk(pe_valid == 3'b000, "R1 dropped push absent", pe_valid, 0);
    chk(!vote_valid, "R3 no hit without siblings", vote_valid, 0);

    // R4/R6: competing hits, lowest index wins; other pattern ignored
    push(0, 8'h66); push(0, 8'h55);
    push(1, 8'h55); push(1, 8'h66);
    push(2, 8'h55); push(2, 8'h66);
    @(negedge clk);
    chk(hit == 3'b111, "R3 hit mask", hit, 3'b111);
    pop(3'b111);
    @(negedge clk);
    chk(!vote_valid, "R4 not yet complete", vote_valid, 0);
    pop(3'b111);
    @(negedge clk);
    chk(vote_valid && vote_pattern == 8'h66, "R4 lowest index pattern", vote_pattern, 8'h66);
    chk(vote_res == exp_res(8'h66, 0), "R7 aligned results", vote_res, exp_res(8'h66, 0));
    accept();
    @(negedge clk);
    chk(!vote_valid, "R8 cleared after accept", vote_valid, 0);
    repeat (3) @(negedge clk);
    chk(!vote_valid && pe_valid == 0, "R6 ignored pattern gives no vote", vote_valid, 0);

    // R5: duplicate pop keeps first result; R7 hold under back-pressure
    push(0, 8'h77);
    push(1, 8'h77); push(1, 8'h77);
    push(2, 8'h44); push(2, 8'h77);
    @(negedge clk);
    chk(hit == 3'b011, "R3 partial hit mask", hit, 3'b011);
    salt = 0;     pop(3'b001);
    salt = 8'h40; pop(3'b010);
    salt = 8'h80; pop(3'b010);
    @(negedge clk);
    chk(!vote_valid, "R5 stream 2 still missing", vote_valid, 0);
    pop(3'b100); pop(3'b100);
    salt = 0;
    @(negedge clk);
    chk(vote_valid && vote_pattern == 8'h77, "R5 pattern", vote_pattern, 8'h77);
    chk(vote_res == exp_res(8'h77, {8'h80, 8'h40, 8'h00}), "R5 first result kept",
        vote_res, exp_res(8'h77, {8'h80, 8'h40, 8'h00}));
    repeat (3) @(negedge clk);
    chk(vote_valid && vote_res == exp_res(8'h77, {8'h80, 8'h40, 8'h00}), "R7 hold",
        vote_res, exp_res(8'h77, {8'h80, 8'h40, 8'h00}));
    accept();

    // sweep: 0..2 unrelated entries ahead of a common pattern per stream
    for (int o0 = 0; o0 < 3; o0++)
      for (int o1 = 0; o1 < 3; o1++)
        for (int o2 = 0; o2 < 3; o2++) begin
          int off [3];
          logic [W-1:0] pa;
          logic [2:0] eh;
          off[0] = o0; off[1] = o1; off[2] = o2;
          pa = 8'hC0 + 8'(o0 * 9 + o1 * 3 + o2);
          for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < off[s]; k++) push(s, 8'(16 * (s + 1) + k));
            push(s, pa);
          end
          eh = {o2 == 0, o1 == 0, o0 == 0};
          @(negedge clk);
          chk(hit == eh, "R3 sweep hit", hit, eh);
          for (int r = 0; r < 3; r++) pop(3'b111);
          @(negedge clk);
          chk(vote_valid && vote_pattern == pa, "R4 sweep pattern", vote_pattern, pa);
          chk(vote_res == exp_res(pa, 0), "R7 sweep results", vote_res, exp_res(pa, 0));
          accept();
          @(negedge clk);
          chk(!vote_valid && pe_valid == 0, "R8 sweep cleared", {vote_valid, pe_valid}, 0);
        end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule